// File: doc/BRIEF.md
# Hardwired Jump Sequencer

This block is a small control unit with no microcode store. A state register holds the current step. Next-state logic works out the following step from that step and from the byte that memory has just returned. A 16-bit program counter drives the address of a byte-wide synchronous memory. The memory returns data one cycle after it sees an address. The sequencer reads one opcode byte, latches it and decodes it.

The value 0xC3 is an unconditional absolute jump. The sequencer reads two more bytes from the next two addresses, takes the first as the low half of the target and the second as the high half, and loads the counter with the result. Every other value finishes as a one-byte no-operation. Debug outputs show the current step and the latched opcode, so a test environment can follow the instruction flow without probing inside the block.

Top module: `jump_seq`

## Requirements
- R1: A synchronous active-high reset forces mem_addr to 0x0000, dbg_state to FETCH (0) and dbg_opcode to 0x00, and holds them there for as long as it stays asserted.
- R2: mem_addr always shows the program counter. The counter goes up by one at the end of each byte-fetch step (FETCH=0, FETCH_LO=3, FETCH_HI=5). It holds in OP_WAIT=1, DECODE=2 and LO_WAIT=4. It changes in HI_WAIT=6 only by loading the jump target.
- R3: Memory read data arrives one cycle after the address. The opcode is captured from mem_rdata at the end of OP_WAIT and shown on dbg_opcode from DECODE onwards, until the next capture.
- R4: An instruction whose opcode is not 0xC3 passes through FETCH, OP_WAIT, DECODE and then FETCH again, which takes three cycles, and it changes nothing except the program counter.
- R5: When the opcode is 0xC3, DECODE is followed by FETCH_LO, LO_WAIT, FETCH_HI, HI_WAIT and then FETCH, so a jump takes seven cycles.
- R6: The byte read at the first operand address is held during the second read. At the end of HI_WAIT the counter loads {second byte, first byte}, and the next FETCH presents that address.
- R7: The program counter wraps from 0xFFFF to 0x0000 when it increments. This holds also while operand bytes are being fetched.
- R8: dbg_state only ever takes the seven codes 0 to 6 listed in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 16 | Program counter, driven as the memory read address |
| mem_rdata | input | 8 | Read data, valid one cycle after the address |
| dbg_state | output | 3 | Current sequencer step code |
| dbg_opcode | output | 8 | Most recently latched opcode byte |

## Verification
The counter wrap and the operand fetch can land in the same cycle. The test program jumps to 0xFFFE, where a second jump opcode sits, so FETCH_LO runs at 0xFFFF and the counter rolls over while the low target byte is in flight. The bench then requires LO_WAIT to show 0x0000, the high byte to come from address 0x0000, and the next FETCH to present the target built from both halves. A reset is also asserted in the middle of a jump, and the bench checks that it overrides the pending operand step at once.

// File: rtl/jump_seq_pkg.sv
package jump_seq_pkg;

  localparam int ST_W = 3;

  typedef enum logic [ST_W-1:0] {
    ST_FETCH    = 3'd0,
    ST_OP_WAIT  = 3'd1,
    ST_DECODE   = 3'd2,
    ST_FETCH_LO = 3'd3,
    ST_LO_WAIT  = 3'd4,
    ST_FETCH_HI = 3'd5,
    ST_HI_WAIT  = 3'd6
  } seq_state_e;

  // Steps that put a byte address on the bus and advance the counter
  function automatic logic is_byte_fetch(seq_state_e s);
    return (s == ST_FETCH) || (s == ST_FETCH_LO) || (s == ST_FETCH_HI);
  endfunction

endpackage

// File: rtl/jump_seq_pc.sv
module jump_seq_pc #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  output logic [ADDR_W-1:0] pc
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  // Modulo-2^ADDR_W step: all ones rolls over to zero
  function automatic logic [ADDR_W-1:0] step(input logic [ADDR_W-1:0] v);
    return v + ONE;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)       pc <= '0;
    else if (load) pc <= load_val;
    else if (inc)  pc <= step(pc);
  end

endmodule

// File: rtl/jump_seq_hold.sv
module jump_seq_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end

endmodule

// File: rtl/jump_seq_ctrl.sv
module jump_seq_ctrl
  import jump_seq_pkg::*;
#(
  parameter int              DATA_W  = 8,
  parameter logic [DATA_W-1:0] JUMP_OP = 8'hC3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] opcode,
  output seq_state_e        state,
  output logic              pc_inc,
  output logic              pc_load,
  output logic              op_cap,
  output logic              lo_cap
);

  seq_state_e nxt;

  function automatic logic is_jump(input logic [DATA_W-1:0] op);
    return op == JUMP_OP;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FETCH;
    else     state <= nxt;
  end

  always_comb begin
    nxt = ST_FETCH;
    unique case (state)
      ST_FETCH:    nxt = ST_OP_WAIT;
      ST_OP_WAIT:  nxt = ST_DECODE;
      ST_DECODE:   nxt = is_jump(opcode) ? ST_FETCH_LO : ST_FETCH;
      ST_FETCH_LO: nxt = ST_LO_WAIT;
      ST_LO_WAIT:  nxt = ST_FETCH_HI;
      ST_FETCH_HI: nxt = ST_HI_WAIT;
      ST_HI_WAIT:  nxt = ST_FETCH;
      default:     nxt = ST_FETCH;
    endcase
  end

  assign pc_inc  = is_byte_fetch(state);
  assign pc_load = (state == ST_HI_WAIT);
  assign op_cap  = (state == ST_OP_WAIT);
  assign lo_cap  = (state == ST_LO_WAIT);

endmodule

// File: rtl/jump_seq.sv
module jump_seq
  import jump_seq_pkg::*;
#(
  parameter int                DATA_W  = 8,
  parameter logic [DATA_W-1:0] JUMP_OP = 8'hC3,
  localparam int               ADDR_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ST_W-1:0]   dbg_state,
  output logic [DATA_W-1:0] dbg_opcode
);

  localparam int SLOT_OP = 0;
  localparam int SLOT_LO = 1;
  localparam int N_SLOTS = 2;

  // Target address: second operand byte on top, first below
  function automatic logic [ADDR_W-1:0] join_target(
    input logic [DATA_W-1:0] hi, input logic [DATA_W-1:0] lo);
    return {hi, lo};
  endfunction

  seq_state_e          state;
  logic                pc_inc, pc_load, op_cap, lo_cap;
  logic [ADDR_W-1:0]   pc, target;
  logic [N_SLOTS-1:0]  cap;
  logic [DATA_W-1:0]   slot_q [N_SLOTS];
  logic [DATA_W-1:0]   opcode_q, lo_byte;

  jump_seq_ctrl #(.DATA_W(DATA_W), .JUMP_OP(JUMP_OP)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .opcode  (opcode_q),
    .state   (state),
    .pc_inc  (pc_inc),
    .pc_load (pc_load),
    .op_cap  (op_cap),
    .lo_cap  (lo_cap)
  );

  assign cap[SLOT_OP] = op_cap;
  assign cap[SLOT_LO] = lo_cap;

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    jump_seq_hold #(.W(DATA_W)) u_hold (
      .clk (clk),
      .rst (rst),
      .en  (cap[g]),
      .d   (mem_rdata),
      .q   (slot_q[g])
    );
  end

  assign opcode_q = slot_q[SLOT_OP];
  assign lo_byte  = slot_q[SLOT_LO];
  assign target   = join_target(mem_rdata, lo_byte);

  jump_seq_pc #(.ADDR_W(ADDR_W)) u_pc (
    .clk      (clk),
    .rst      (rst),
    .inc      (pc_inc),
    .load     (pc_load),
    .load_val (target),
    .pc       (pc)
  );

  assign mem_addr   = pc;
  assign dbg_state  = state;
  assign dbg_opcode = opcode_q;

endmodule

// File: rtl/jump_seq_chk.sv
module jump_seq_chk
  import jump_seq_pkg::*;
#(
  parameter int                DATA_W  = 8,
  parameter logic [DATA_W-1:0] JUMP_OP = 8'hC3,
  localparam int               ADDR_W  = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_rdata,
  input logic [ST_W-1:0]   dbg_state,
  input logic [DATA_W-1:0] dbg_opcode,
  input logic [DATA_W-1:0] lo_byte
);

  localparam logic [ADDR_W-1:0] ALL_ONES = '1;

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (dbg_state == ST_FETCH && mem_addr == '0 && dbg_opcode == '0));

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    (dbg_state == ST_FETCH || dbg_state == ST_FETCH_LO || dbg_state == ST_FETCH_HI)
    |=> mem_addr == ADDR_W'($past(mem_addr) + ADDR_W'(1)));

  assert_pc_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (dbg_state == ST_OP_WAIT || dbg_state == ST_DECODE || dbg_state == ST_LO_WAIT)
    |=> $stable(mem_addr));

  assert_opcode_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (dbg_state != ST_OP_WAIT) |=> $stable(dbg_opcode));

  assert_nop_return_R4: assert property (@(posedge clk) disable iff (rst)
    (dbg_state == ST_DECODE && dbg_opcode != JUMP_OP) |=> dbg_state == ST_FETCH);

  assert_jump_enter_R5: assert property (@(posedge clk) disable iff (rst)
    (dbg_state == ST_DECODE && dbg_opcode == JUMP_OP) |=> dbg_state == ST_FETCH_LO);

  assert_target_load_R6: assert property (@(posedge clk) disable iff (rst)
    (dbg_state == ST_HI_WAIT)
    |=> (mem_addr == {$past(mem_rdata), $past(lo_byte)} && dbg_state == ST_FETCH));

  assert_pc_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    ((dbg_state == ST_FETCH || dbg_state == ST_FETCH_LO || dbg_state == ST_FETCH_HI)
     && mem_addr == ALL_ONES) |=> mem_addr == '0);

  assert_legal_code_R8: assert property (@(posedge clk) disable iff (rst)
    dbg_state <= ST_HI_WAIT);

endmodule

bind jump_seq jump_seq_chk #(.DATA_W(DATA_W), .JUMP_OP(JUMP_OP)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mem_addr   (mem_addr),
  .mem_rdata  (mem_rdata),
  .dbg_state  (dbg_state),
  .dbg_opcode (dbg_opcode),
  .lo_byte    (lo_byte)
);

// File: tb/sim_jump_seq.sv
`timescale 1ns/1ps
module sim_jump_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic [2:0]  dbg_state;
  logic [7:0]  dbg_opcode;
  logic [7:0]  mem [256];
  int          n_run = 0;
  int          n_fail = 0;
  logic        done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  // Byte memory, one cycle of read latency, aliased on the low address byte
  always_ff @(posedge clk) mem_rdata <= mem[mem_addr[7:0]];

  jump_seq u0 (
    .clk        (clk),
    .rst        (rst),
    .mem_addr   (mem_addr),
    .mem_rdata  (mem_rdata),
    .dbg_state  (dbg_state),
    .dbg_opcode (dbg_opcode)
  );

  // Entry: {check_opcode, state, addr, opcode}, one per cycle after reset release
  localparam int NT = 38;
  localparam logic [27:0] TRACE [NT] = '{
    {1'b0, 3'd0, 16'h0000, 8'h00}, {1'b0, 3'd1, 16'h0001, 8'h00},
    {1'b1, 3'd2, 16'h0001, 8'h00}, {1'b0, 3'd0, 16'h0001, 8'h00},
    {1'b0, 3'd1, 16'h0002, 8'h00}, {1'b1, 3'd2, 16'h0002, 8'hC3},
    {1'b0, 3'd3, 16'h0002, 8'h00}, {1'b0, 3'd4, 16'h0003, 8'h00},
    {1'b0, 3'd5, 16'h0003, 8'h00}, {1'b0, 3'd6, 16'h0004, 8'h00},
    {1'b0, 3'd0, 16'h0010, 8'h00}, {1'b0, 3'd1, 16'h0011, 8'h00},
    {1'b1, 3'd2, 16'h0011, 8'hC2}, {1'b0, 3'd0, 16'h0011, 8'h00},
    {1'b0, 3'd1, 16'h0012, 8'h00}, {1'b1, 3'd2, 16'h0012, 8'hC3},
    {1'b0, 3'd3, 16'h0012, 8'h00}, {1'b0, 3'd4, 16'h0013, 8'h00},
    {1'b0, 3'd5, 16'h0013, 8'h00}, {1'b0, 3'd6, 16'h0014, 8'h00},
    {1'b0, 3'd0, 16'hFFFE, 8'h00}, {1'b0, 3'd1, 16'hFFFF, 8'h00},
    {1'b1, 3'd2, 16'hFFFF, 8'hC3}, {1'b0, 3'd3, 16'hFFFF, 8'h00},
    {1'b0, 3'd4, 16'h0000, 8'h00}, {1'b0, 3'd5, 16'h0000, 8'h00},
    {1'b0, 3'd6, 16'h0001, 8'h00}, {1'b0, 3'd0, 16'h0040, 8'h00},
    {1'b0, 3'd1, 16'h0041, 8'h00}, {1'b1, 3'd2, 16'h0041, 8'hFF},
    {1'b0, 3'd0, 16'h0041, 8'h00}, {1'b0, 3'd1, 16'h0042, 8'h00},
    {1'b1, 3'd2, 16'h0042, 8'hC3}, {1'b0, 3'd3, 16'h0042, 8'h00},
    {1'b0, 3'd4, 16'h0043, 8'h00}, {1'b0, 3'd5, 16'h0043, 8'h00},
    {1'b0, 3'd6, 16'h0044, 8'h00}, {1'b0, 3'd0, 16'h0001, 8'h00}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [2:0] st, input logic [15:0] a);
    if (a == 16'h0000 && st == 3'd4) return "R7 wrap during operand fetch";
    if (st >= 3'd3)                  return "R5/R6 jump sequence";
    return "R2/R4 fetch and no-op flow";
  endfunction

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    mem[8'h01] = 8'hC3; mem[8'h02] = 8'h10; mem[8'h03] = 8'h00;  // to 0x0010
    mem[8'h10] = 8'hC2;                                            // no-op
    mem[8'h11] = 8'hC3; mem[8'h12] = 8'hFE; mem[8'h13] = 8'hFF;  // to 0xFFFE
    mem[8'hFE] = 8'hC3; mem[8'hFF] = 8'h40;                       // hi from 0x0000
    mem[8'h40] = 8'hFF;                                            // no-op
    mem[8'h41] = 8'hC3; mem[8'h42] = 8'h01; mem[8'h43] = 8'h00;  // to 0x0001

    repeat (3) @(negedge clk);
    check("R1 reset state", 32'(dbg_state), 32'd0);
    check("R1 reset addr", 32'(mem_addr), 32'h0000);
    check("R1 reset opcode", 32'(dbg_opcode), 32'h00);

    rst = 1'b0;
    for (int k = 0; k < NT; k++) begin
      check({req_of(TRACE[k][26:24], TRACE[k][23:8]), " state"},
            32'(dbg_state), 32'(TRACE[k][26:24]));
      check({req_of(TRACE[k][26:24], TRACE[k][23:8]), " addr"},
            32'(mem_addr), 32'(TRACE[k][23:8]));
      if (TRACE[k][27])
        check("R3 latched opcode", 32'(dbg_opcode), 32'(TRACE[k][7:0]));
      @(negedge clk);
    end

    // Reset in the middle of a jump (cycle 41 is LO_WAIT at 0x0003)
    repeat (3) @(negedge clk);
    check("R5 mid-jump state", 32'(dbg_state), 32'd4);
    check("R6 mid-jump addr", 32'(mem_addr), 32'h0003);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset overrides jump state", 32'(dbg_state), 32'd0);
    check("R1 reset overrides jump addr", 32'(mem_addr), 32'h0000);
    check("R1 reset clears opcode", 32'(dbg_opcode), 32'h00);
    @(negedge clk);
    check("R1 reset held state", 32'(dbg_state), 32'd0);
    check("R1 reset held addr", 32'(mem_addr), 32'h0000);
    rst = 1'b0;
    @(negedge clk);
    check("R2 restart addr", 32'(mem_addr), 32'h0001);
    check("R8 restart state", 32'(dbg_state), 32'd1);
    @(negedge clk);
    check("R4 restart decode", 32'(dbg_state), 32'd2);
    check("R3 restart opcode", 32'(dbg_opcode), 32'h00);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog R1..R8 actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule